// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block turns a PCI interrupt pin request into a system interrupt number for a device on the primary bus. It rotates the requested pin by the low two bits of the slot number and looks the result up in a four-entry table. Each entry is either a default built from a base interrupt number or a value written into an override register. A two-bit mode field picks the default scheme. Modes 0 and 1 give all four pins one shared interrupt. Modes 2 and 3 give pin index k its own interrupt, base plus k.

The same table gates the four incoming active-low interrupt levels. A level reaches the output request vector only when two things hold: its bit is set in the enable mask, and its table entry is not zero. An entry of zero means the pin is not assigned. A small write-only register port loads the four override registers and the enable mask. Both results come out of one register stage each.

Top module: `pci_irq_router`

## Requirements
- R1: A pin number outside 1..4 (including 0 and any value of 5 or more) makes `sys_irq_o` equal 0 one cycle later.
- R2: For a valid pin, the table index is ((pin − 1) + slot) mod 4, so only slot bits [1:0] affect the result; `sys_irq_o` holds the selected entry one cycle after the inputs.
- R3: With `irq_mode_i` equal to 0 or 1 and no override, every table entry equals `base_irq_i`.
- R4: With `irq_mode_i` equal to 2 or 3 and no override, entry k equals `base_irq_i` + k, modulo 256.
- R5: Register addresses 0..3 hold the override for table index 0..3. The value 0xFF selects the default entry; any other value replaces it.
- R6: `irq_req_o[k]` is the inverse of `intx_n_i[k]` ANDed with enable bit k, registered once. Bit k is pin index k, with 0 for the first pin.
- R7: A table entry of 0 disables its pin, so `irq_req_o` for that index stays 0 whatever its mask bit holds.
- R8: Register address 4 loads the enable mask from write-data bits [3:0]. Data bits [7:4], which include bit 4 (the error-interrupt enable kept in another unit), are ignored here. Writes to addresses 5..7 change nothing.
- R9: Reset, which is synchronous and active high, sets all overrides to 0xFF, the mask to 0, and both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_i | input | 5 | Slot number of the requesting device |
| pin_i | input | 8 | Interrupt pin number (1..4 valid) |
| irq_mode_i | input | 2 | Interrupt mode: below 2 shared, 2 or more distinct |
| base_irq_i | input | 8 | Base system interrupt number |
| intx_n_i | input | 4 | Incoming PCI interrupt levels, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0..3 overrides, 4 mask) |
| reg_wdata_i | input | 8 | Register write data |
| sys_irq_o | output | 8 | Resolved system interrupt number |
| irq_req_o | output | 4 | Masked interrupt request vector |

## Verification
A change on slot, pin, mode or base appears on `sys_irq_o` at the next rising edge. A change on the interrupt levels appears on `irq_req_o` at that same edge. A register write takes effect at its own edge, and its effect reaches either output one edge later. The bench drives every input on the falling edge. For a resolution it waits one full cycle and samples at the next falling edge. After a write it lets one more edge pass before sampling, so every check reads a settled registered value.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    MODE_SHARED_A = 2'd0,
    MODE_SHARED_B = 2'd1,
    MODE_SPREAD_A = 2'd2,
    MODE_SPREAD_B = 2'd3
  } irq_mode_e;

  function automatic logic mode_is_spread(input logic [1:0] mode);
    return (irq_mode_e'(mode) == MODE_SPREAD_A) || (irq_mode_e'(mode) == MODE_SPREAD_B);
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_PINS = 4,
  parameter int IRQ_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [IRQ_W-1:0]                   wdata_i,
  output logic [NUM_PINS-1:0][IRQ_W-1:0]     ovr_o,
  output logic [NUM_PINS-1:0]                mask_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_PINS);
  localparam logic [IRQ_W-1:0]  USE_DFLT  = '1;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_ovr
    always_ff @(posedge clk_i) begin
      if (rst_i)
        ovr_o[k] <= USE_DFLT;
      else if (we_i && addr_i == ADDR_W'(k))
        ovr_o[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      mask_o <= '0;
    else if (we_i && addr_i == CTRL_ADDR)
      mask_o <= wdata_i[NUM_PINS-1:0];
  end

  // R8
  mask_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == CTRL_ADDR) |=> (mask_o == $past(wdata_i[NUM_PINS-1:0])));

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!we_i || addr_i != CTRL_ADDR) |=> $stable(mask_o));

  // R9
  reset_val_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> ((&ovr_o) && mask_o == '0));

endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int IRQ_W    = 8
) (
  input  logic [1:0]                         mode_i,
  input  logic [IRQ_W-1:0]                   base_i,
  input  logic [NUM_PINS-1:0][IRQ_W-1:0]     ovr_i,
  output logic [NUM_PINS-1:0][IRQ_W-1:0]     entry_o,
  output logic [NUM_PINS-1:0]                live_o
);
  localparam logic [IRQ_W-1:0] USE_DFLT = '1;

  logic spread;
  assign spread = mode_is_spread(mode_i);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_entry
    logic [IRQ_W-1:0] dflt;
    always_comb begin
      dflt = spread ? (base_i + IRQ_W'(k)) : base_i;
      entry_o[k] = (ovr_i[k] == USE_DFLT) ? dflt : ovr_i[k];
      live_o[k]  = (entry_o[k] != '0);
    end
  end

endmodule

// File: rtl/irq_pin_select.sv
module irq_pin_select #(
  parameter int NUM_PINS = 4,
  parameter int IRQ_W    = 8,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic [SLOT_W-1:0]                  slot_i,
  input  logic [PIN_W-1:0]                   pin_i,
  input  logic [NUM_PINS-1:0][IRQ_W-1:0]     entry_i,
  output logic [IRQ_W-1:0]                   sys_irq_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic             pin_ok;
  logic [IDX_W-1:0] idx;
  logic [IRQ_W-1:0] pick;

  always_comb begin
    pin_ok = (pin_i != '0) && (32'(pin_i) <= NUM_PINS);
    idx    = IDX_W'((32'(pin_i) + 32'(slot_i) - 1) % NUM_PINS);
    pick   = pin_ok ? entry_i[idx] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sys_irq_o <= '0;
    else       sys_irq_o <= pick;
  end

  // R1
  bad_pin_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!pin_ok) |=> (sys_irq_o == '0));

endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] intx_n_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] live_i,
  output logic [NUM_PINS-1:0] irq_req_o
);
  logic [NUM_PINS-1:0] en;
  assign en = mask_i & live_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_req_o <= '0;
    else       irq_req_o <= ~intx_n_i & en;
  end

  // R6
  req_in_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((irq_req_o & ~$past(mask_i)) == '0));

  // R7
  dead_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_i == '0) |=> (irq_req_o == '0));

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int NUM_PINS = 4,
  parameter int IRQ_W    = 8,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [PIN_W-1:0]    pin_i,
  input  logic [1:0]          irq_mode_i,
  input  logic [IRQ_W-1:0]    base_irq_i,
  input  logic [NUM_PINS-1:0] intx_n_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [IRQ_W-1:0]    reg_wdata_i,
  output logic [IRQ_W-1:0]    sys_irq_o,
  output logic [NUM_PINS-1:0] irq_req_o
);
  logic [NUM_PINS-1:0][IRQ_W-1:0] ovr;
  logic [NUM_PINS-1:0][IRQ_W-1:0] entry;
  logic [NUM_PINS-1:0]            mask;
  logic [NUM_PINS-1:0]            live;

  irq_cfg_regs #(.NUM_PINS(NUM_PINS), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .ovr_o(ovr), .mask_o(mask)
  );

  irq_entry_table #(.NUM_PINS(NUM_PINS), .IRQ_W(IRQ_W)) u_table (
    .mode_i(irq_mode_i), .base_i(base_irq_i), .ovr_i(ovr),
    .entry_o(entry), .live_o(live)
  );

  irq_pin_select #(.NUM_PINS(NUM_PINS), .IRQ_W(IRQ_W), .SLOT_W(SLOT_W), .PIN_W(PIN_W)) u_sel (
    .clk_i(clk_i), .rst_i(rst_i), .slot_i(slot_i), .pin_i(pin_i),
    .entry_i(entry), .sys_irq_o(sys_irq_o)
  );

  irq_level_gate #(.NUM_PINS(NUM_PINS)) u_gate (
    .clk_i(clk_i), .rst_i(rst_i), .intx_n_i(intx_n_i), .mask_i(mask),
    .live_i(live), .irq_req_o(irq_req_o)
  );

  // R3
  shared_base_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pin_i != '0 && 32'(pin_i) <= NUM_PINS && !irq_mode_i[1] && (&ovr))
      |=> (sys_irq_o == $past(base_irq_i)));

endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] slot = '0;
  logic [7:0] pin = '0;
  logic [1:0] mode = '0;
  logic [7:0] base = '0;
  logic [3:0] intx_n = 4'hF;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] sys_irq;
  logic [3:0] irq_req;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [4] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
  logic [3:0] shadow_mask = '0;

  always #4 clk = ~clk;

  pci_irq_router uut (
    .clk_i(clk), .rst_i(rst), .slot_i(slot), .pin_i(pin), .irq_mode_i(mode),
    .base_irq_i(base), .intx_n_i(intx_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .sys_irq_o(sys_irq), .irq_req_o(irq_req)
  );

  function automatic logic [7:0] model_entry(input int k);
    if (shadow[k] != 8'hFF) return shadow[k];
    return mode[1] ? 8'(base + 8'(k)) : base;
  endfunction

  function automatic logic [7:0] model_irq(input logic [7:0] p, input logic [4:0] s);
    if (p < 1 || p > 4) return 8'h00;
    return model_entry((int'(p) - 1 + int'(s[1:0])) % 4);
  endfunction

  function automatic logic [3:0] model_req();
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[k] = !intx_n[k] && shadow_mask[k] && (model_entry(k) != 8'h00);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a < 3'd4) shadow[a] = d;
    else if (a == 3'd4) shadow_mask = d[3:0];
  endtask

  task automatic resolve(input string req, input logic [7:0] p, input logic [4:0] s);
    pin = p; slot = s;
    @(negedge clk);
    check(req, sys_irq, model_irq(p, s));
  endtask

  task automatic t_reset();
    check("R9 sys_irq", sys_irq, 8'h00);
    check("R9 irq_req", irq_req, 4'h0);
    intx_n = 4'h0; mode = 2'd0; base = 8'd9;
    resolve("R9 override default", 8'd1, 5'd0);
    check("R9 mask zero", irq_req, 4'h0);
    intx_n = 4'hF;
  endtask

  task automatic t_shared();
    base = 8'd9;
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      for (int p = 1; p <= 4; p++) resolve("R3 shared", 8'(p), 5'(p * 3));
    end
  endtask

  task automatic t_distinct();
    base = 8'd20;
    for (int m = 2; m < 4; m++) begin
      mode = 2'(m);
      for (int p = 1; p <= 4; p++)
        for (int s = 0; s < 8; s++) resolve("R2 R4 rotate", 8'(p), 5'(s * 5));
    end
    base = 8'd254;
    resolve("R4 wrap", 8'd4, 5'd0);
    check("R4 wrap value", sys_irq, 8'd1);
  endtask

  task automatic t_invalid();
    mode = 2'd2; base = 8'd40;
    resolve("R1 pin0", 8'd0, 5'd1);
    resolve("R1 pin5", 8'd5, 5'd2);
    resolve("R1 pin255", 8'd255, 5'd3);
  endtask

  task automatic t_override();
    mode = 2'd2; base = 8'd20;
    reg_write(3'd2, 8'h33);
    resolve("R5 replaced", 8'd3, 5'd0);
    check("R5 replaced value", sys_irq, 8'h33);
    resolve("R5 neighbour", 8'd2, 5'd0);
    resolve("R5 rotated", 8'd1, 5'd1);
    reg_write(3'd2, 8'hFF);
    resolve("R5 restored", 8'd3, 5'd0);
    check("R5 restored value", sys_irq, 8'd22);
  endtask

  task automatic t_mask();
    mode = 2'd2; base = 8'd20;
    reg_write(3'd4, 8'hF5);
    intx_n = 4'h0;
    @(negedge clk);
    check("R8 upper bits ignored", irq_req, 4'h5);
    intx_n = 4'b1010;
    @(negedge clk);
    check("R6 level gate", irq_req, model_req());
    reg_write(3'd6, 8'hFF);
    reg_write(3'd5, 8'hFF);
    @(negedge clk);
    check("R8 high addr ignored", irq_req, 4'h5);
    reg_write(3'd4, 8'h0A);
    intx_n = 4'b0110;
    @(negedge clk);
    check("R6 mask A", irq_req, model_req());
  endtask

  task automatic t_zero_entry();
    reg_write(3'd4, 8'h0F);
    mode = 2'd0; base = 8'd0; intx_n = 4'h0;
    @(negedge clk);
    check("R7 all dead", irq_req, 4'h0);
    reg_write(3'd1, 8'd7);
    @(negedge clk);
    check("R7 one live", irq_req, 4'h2);
    resolve("R7 dead entry number", 8'd1, 5'd0);
    mode = 2'd2;
    @(negedge clk);
    check("R7 spread base0", irq_req, model_req());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_shared();
    t_distinct();
    t_invalid();
    t_override();
    t_mask();
    t_zero_entry();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule